// File: doc/BRIEF.md
# Carry-Selectable Arithmetic Slice

This block is one narrow slice of an arithmetic datapath. It holds two accumulators and two data registers and, on every clock edge, can increment or decrement an accumulator, add a data register to it, or subtract a data register from it. The result goes back into the accumulator that was named as the destination. A load operation writes an external byte into an accumulator, and the data registers are written through a separate port.

The carry that enters the least significant bit is picked per cycle. Two carry-source settings are held on input ports, and a one-bit pick input chooses which setting governs the current cycle. Each setting names one of four sources: the operation's natural carry, the carry-out this slice registered on its last arithmetic cycle, a routed hardware signal, or the carry of a neighbouring, less significant slice. The slice exposes its carry-out, the registered carry and a signed-overflow flag, so wider words can be built either by chaining slices within a single cycle or by running one slice over several cycles.

Top module: `dp_slice`

## Requirements
- R1: Opcode 1 (increment) computes acc + 0 + cin; with the natural carry source this is acc + 1. The result appears on `alu_y` in the same cycle and is written into the accumulator chosen by `acc_sel` at the next clock edge.
- R2: Opcode 2 (decrement) computes acc + all-ones + cin; the natural carry for it is 0, giving acc - 1. Result written back as in R1.
- R3: Opcode 3 (add) computes acc + D + cin with natural carry 0; opcode 4 (subtract) computes acc + ~D + cin with natural carry 1, i.e. acc - D. D is the data register chosen by `opnd_sel`. Result written back as in R1.
- R4: A carry setting value 0 selects the natural carry of the operation, 1 selects the registered carry `co_held`, 2 selects `ci_routed`, 3 selects `ci_chained`.
- R5: When `ci_cfg_pick` is 0 the setting on `ci_cfg_a` governs the cycle; when it is 1 the setting on `ci_cfg_b` governs it.
- R6: `co_msb` is the carry out of the most significant bit of the 9-bit sum of the current operation.
- R7: `ov` is the carry out of the MSB XOR the carry out of bit MSB-1, i.e. set when both addends share a sign and the result sign differs.
- R8: `co_held` takes the value of `co_msb` at every clock edge where opcode 1 to 4 executes, holds otherwise, and is 0 after reset.
- R9: Opcodes 0, 6 and 7 change no accumulator and no carry state; opcode 5 writes `load_data` into the accumulator selected by `acc_sel`. For opcodes 0 and 5 to 7, `alu_y` shows the selected accumulator and `co_msb` and `ov` are 0.
- R10: `dreg_we` writes `dreg_wdata` into the data register chosen by `dreg_idx` at the clock edge; an operation in the same cycle reads the old value. Synchronous reset `rst` clears all accumulators, data registers and `co_held` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 3 | Operation code |
| acc_sel | input | 1 | Destination and source accumulator |
| opnd_sel | input | 1 | Data register used as second operand |
| ci_cfg_a | input | 2 | Carry-source setting A |
| ci_cfg_b | input | 2 | Carry-source setting B |
| ci_cfg_pick | input | 1 | Chooses setting A (0) or B (1) this cycle |
| ci_routed | input | 1 | Routed carry input |
| ci_chained | input | 1 | Carry from less significant slice |
| dreg_we | input | 1 | Data register write enable |
| dreg_idx | input | 1 | Data register write index |
| dreg_wdata | input | 8 | Data register write value |
| load_data | input | 8 | Value for the load operation |
| acc_flat | output | 16 | Accumulators, accumulator 0 in the low byte |
| alu_y | output | 8 | Combinational result |
| co_msb | output | 1 | Carry out of the MSB |
| co_held | output | 1 | Registered carry |
| ov | output | 1 | Signed overflow |

## Verification
The registered carry is both consumed and replaced in the same cycle when a setting selects source 1 during an arithmetic operation: the sum must use the carry from the previous arithmetic cycle while `co_held` captures the new carry-out at the edge. Random sequences that repeatedly pick source 1 on back-to-back operations, with idle and load cycles interleaved, provoke this; a reference model in the bench predicts the sum from the old carry and then the new held carry, and both are compared. Data-register writes aimed at the operand being read in the same cycle are judged the same way.

// File: rtl/dp_slice_pkg.sv
package dp_slice_pkg;

    localparam int OPC_W = 3;

    typedef enum logic [OPC_W-1:0] {
        OP_IDLE = 3'd0,
        OP_INC  = 3'd1,
        OP_DEC  = 3'd2,
        OP_ADD  = 3'd3,
        OP_SUB  = 3'd4,
        OP_LOAD = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        CI_NATURAL = 2'd0,
        CI_HELD    = 2'd1,
        CI_ROUTED  = 2'd2,
        CI_CHAINED = 2'd3
    } ci_src_e;

    typedef enum logic [1:0] {
        B_ZERO = 2'd0,
        B_ONES = 2'd1,
        B_REG  = 2'd2,
        B_INV  = 2'd3
    } bsrc_e;

    typedef struct packed {
        logic  arith;
        logic  load;
        bsrc_e bsrc;
        logic  nat_cin;
    } ctl_t;

    function automatic ctl_t decode_op(input logic [OPC_W-1:0] code);
        ctl_t c;
        c = '{arith: 1'b0, load: 1'b0, bsrc: B_ZERO, nat_cin: 1'b0};
        case (op_e'(code))
            OP_INC:  c = '{arith: 1'b1, load: 1'b0, bsrc: B_ZERO, nat_cin: 1'b1};
            OP_DEC:  c = '{arith: 1'b1, load: 1'b0, bsrc: B_ONES, nat_cin: 1'b0};
            OP_ADD:  c = '{arith: 1'b1, load: 1'b0, bsrc: B_REG,  nat_cin: 1'b0};
            OP_SUB:  c = '{arith: 1'b1, load: 1'b0, bsrc: B_INV,  nat_cin: 1'b1};
            OP_LOAD: c = '{arith: 1'b0, load: 1'b1, bsrc: B_ZERO, nat_cin: 1'b0};
            default: c = '{arith: 1'b0, load: 1'b0, bsrc: B_ZERO, nat_cin: 1'b0};
        endcase
        return c;
    endfunction

    function automatic ci_src_e pick_setting(input logic [1:0] cfg_a,
                                             input logic [1:0] cfg_b,
                                             input logic       pick);
        return pick ? ci_src_e'(cfg_b) : ci_src_e'(cfg_a);
    endfunction

endpackage

// File: rtl/dp_regbank.sv
module dp_regbank #(
    parameter int W      = 8,
    parameter int N_ACC  = 2,
    parameter int N_DREG = 2,
    localparam int AW    = (N_ACC  > 1) ? $clog2(N_ACC)  : 1,
    localparam int DW    = (N_DREG > 1) ? $clog2(N_DREG) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       acc_we,
    input  logic [AW-1:0]              acc_idx,
    input  logic [W-1:0]               acc_wdata,
    input  logic                       d_we,
    input  logic [DW-1:0]              d_idx,
    input  logic [W-1:0]               d_wdata,
    output logic [N_ACC-1:0][W-1:0]    acc_q,
    output logic [N_DREG-1:0][W-1:0]   d_q
);

    for (genvar i = 0; i < N_ACC; i++) begin : g_acc
        always_ff @(posedge clk) begin
            if (rst) begin
                acc_q[i] <= '0;
            end else if (acc_we && (acc_idx == AW'(i))) begin
                acc_q[i] <= acc_wdata;
            end
        end
    end

    for (genvar j = 0; j < N_DREG; j++) begin : g_dreg
        always_ff @(posedge clk) begin
            if (rst) begin
                d_q[j] <= '0;
            end else if (d_we && (d_idx == DW'(j))) begin
                d_q[j] <= d_wdata;
            end
        end
    end

endmodule

// File: rtl/dp_carry_mux.sv
module dp_carry_mux
    import dp_slice_pkg::*;
(
    input  logic       arith,
    input  logic [1:0] cfg_a,
    input  logic [1:0] cfg_b,
    input  logic       pick,
    input  logic       nat_cin,
    input  logic       held,
    input  logic       routed,
    input  logic       chained,
    output logic       cin
);

    ci_src_e src;

    always_comb begin
        src = pick_setting(cfg_a, cfg_b, pick);
        cin = 1'b0;
        if (arith) begin
            case (src)
                CI_NATURAL: cin = nat_cin;
                CI_HELD:    cin = held;
                CI_ROUTED:  cin = routed;
                CI_CHAINED: cin = chained;
                default:    cin = nat_cin;
            endcase
        end
    end

endmodule

// File: rtl/dp_ripple_add.sv
module dp_ripple_add #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         c_top,
    output logic         c_below_top
);

    logic [W:0] c;

    assign c[0] = cin;

    for (genvar k = 0; k < W; k++) begin : g_bit
        assign sum[k]  = a[k] ^ b[k] ^ c[k];
        assign c[k+1]  = (a[k] & b[k]) | (c[k] & (a[k] ^ b[k]));
    end

    assign c_top       = c[W];
    assign c_below_top = c[W-1];

endmodule

// File: rtl/dp_slice.sv
module dp_slice
    import dp_slice_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int N_ACC  = 2,
    parameter int N_DREG = 2,
    localparam int AW    = (N_ACC  > 1) ? $clog2(N_ACC)  : 1,
    localparam int DW    = (N_DREG > 1) ? $clog2(N_DREG) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [OPC_W-1:0]          op,
    input  logic [AW-1:0]             acc_sel,
    input  logic [DW-1:0]             opnd_sel,
    input  logic [1:0]                ci_cfg_a,
    input  logic [1:0]                ci_cfg_b,
    input  logic                      ci_cfg_pick,
    input  logic                      ci_routed,
    input  logic                      ci_chained,
    input  logic                      dreg_we,
    input  logic [DW-1:0]             dreg_idx,
    input  logic [DATA_W-1:0]         dreg_wdata,
    input  logic [DATA_W-1:0]         load_data,
    output logic [N_ACC*DATA_W-1:0]   acc_flat,
    output logic [DATA_W-1:0]         alu_y,
    output logic                      co_msb,
    output logic                      co_held,
    output logic                      ov
);

    ctl_t                           ctl;
    logic [N_ACC-1:0][DATA_W-1:0]   acc_q;
    logic [N_DREG-1:0][DATA_W-1:0]  d_q;
    logic [DATA_W-1:0]              opa;
    logic [DATA_W-1:0]              opb;
    logic                           cin;
    logic                           c_top;
    logic                           c_below;
    logic                           acc_we;
    logic [DATA_W-1:0]              acc_wdata;

    assign ctl = decode_op(op);
    assign opa = acc_q[acc_sel];

    always_comb begin
        case (ctl.bsrc)
            B_ONES:  opb = '1;
            B_REG:   opb = d_q[opnd_sel];
            B_INV:   opb = ~d_q[opnd_sel];
            default: opb = '0;
        endcase
    end

    dp_carry_mux u_cmux (
        .arith   (ctl.arith),
        .cfg_a   (ci_cfg_a),
        .cfg_b   (ci_cfg_b),
        .pick    (ci_cfg_pick),
        .nat_cin (ctl.nat_cin),
        .held    (co_held),
        .routed  (ci_routed),
        .chained (ci_chained),
        .cin     (cin)
    );

    dp_ripple_add #(.W(DATA_W)) u_add (
        .a           (opa),
        .b           (opb),
        .cin         (cin),
        .sum         (alu_y),
        .c_top       (c_top),
        .c_below_top (c_below)
    );

    assign co_msb = ctl.arith & c_top;
    assign ov     = ctl.arith & (c_top ^ c_below);

    assign acc_we    = ctl.arith | ctl.load;
    assign acc_wdata = ctl.load ? load_data : alu_y;

    dp_regbank #(.W(DATA_W), .N_ACC(N_ACC), .N_DREG(N_DREG)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .acc_we    (acc_we),
        .acc_idx   (acc_sel),
        .acc_wdata (acc_wdata),
        .d_we      (dreg_we),
        .d_idx     (dreg_idx),
        .d_wdata   (dreg_wdata),
        .acc_q     (acc_q),
        .d_q       (d_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            co_held <= 1'b0;
        end else if (ctl.arith) begin
            co_held <= c_top;
        end
    end

    assign acc_flat = acc_q;

endmodule

// File: rtl/dp_slice_chk.sv
module dp_slice_chk #(
    parameter int DATA_W = 8,
    parameter int N_ACC  = 2,
    parameter int AW     = 1
) (
    input logic                    clk,
    input logic                    rst,
    input logic [2:0]              op,
    input logic [AW-1:0]           acc_sel,
    input logic [N_ACC*DATA_W-1:0] acc_flat,
    input logic [DATA_W-1:0]       alu_y,
    input logic                    co_msb,
    input logic                    co_held,
    input logic                    ov
);

    logic is_arith;
    logic is_quiet;
    logic [DATA_W-1:0] acc_cur;

    assign is_arith = (op >= 3'd1) && (op <= 3'd4);
    assign is_quiet = (op == 3'd0) || (op == 3'd6) || (op == 3'd7);
    assign acc_cur  = acc_flat[acc_sel*DATA_W +: DATA_W];

    // R1 R2 R3: arithmetic result lands in the selected accumulator
    assert_writeback_R1: assert property (@(posedge clk) disable iff (rst)
        is_arith |=> acc_flat[$past(acc_sel)*DATA_W +: DATA_W] == $past(alu_y));

    // R8: registered carry follows the carry-out of an arithmetic cycle
    assert_carry_capture_R8: assert property (@(posedge clk) disable iff (rst)
        is_arith |=> co_held == $past(co_msb));

    assert_carry_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !is_arith |=> $stable(co_held));

    // R9: idle opcodes leave every accumulator untouched
    assert_idle_stable_R9: assert property (@(posedge clk) disable iff (rst)
        is_quiet |=> $stable(acc_flat));

    assert_idle_flags_R9: assert property (@(posedge clk) disable iff (rst)
        !is_arith |-> (!co_msb && !ov && alu_y == acc_cur));

    // R7: an increment can only overflow into the most negative value
    assert_inc_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        (op == 3'd1 && ov) |-> alu_y == {1'b1, {(DATA_W-1){1'b0}}});

    // R6: decrement of a nonzero value always carries out
    assert_dec_carry_R6: assert property (@(posedge clk) disable iff (rst)
        (op == 3'd2 && acc_cur != '0) |-> co_msb);

endmodule

bind dp_slice dp_slice_chk #(.DATA_W(DATA_W), .N_ACC(N_ACC), .AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .acc_sel  (acc_sel),
    .acc_flat (acc_flat),
    .alu_y    (alu_y),
    .co_msb   (co_msb),
    .co_held  (co_held),
    .ov       (ov)
);

// File: tb/tb_dp_slice.sv
module tb_dp_slice;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op = '0;
    logic [0:0]  acc_sel = '0;
    logic [0:0]  opnd_sel = '0;
    logic [1:0]  ci_cfg_a = '0;
    logic [1:0]  ci_cfg_b = '0;
    logic        ci_cfg_pick = 1'b0;
    logic        ci_routed = 1'b0;
    logic        ci_chained = 1'b0;
    logic        dreg_we = 1'b0;
    logic [0:0]  dreg_idx = '0;
    logic [7:0]  dreg_wdata = '0;
    logic [7:0]  load_data = '0;
    logic [15:0] acc_flat;
    logic [7:0]  alu_y;
    logic        co_msb;
    logic        co_held;
    logic        ov;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [7:0] m_acc [2];
    logic [7:0] m_d   [2];
    logic       m_coq;

    always #2.5 clk = ~clk;

    dp_slice dut (
        .clk(clk), .rst(rst), .op(op), .acc_sel(acc_sel), .opnd_sel(opnd_sel),
        .ci_cfg_a(ci_cfg_a), .ci_cfg_b(ci_cfg_b), .ci_cfg_pick(ci_cfg_pick),
        .ci_routed(ci_routed), .ci_chained(ci_chained),
        .dreg_we(dreg_we), .dreg_idx(dreg_idx), .dreg_wdata(dreg_wdata),
        .load_data(load_data), .acc_flat(acc_flat), .alu_y(alu_y),
        .co_msb(co_msb), .co_held(co_held), .ov(ov)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit arith_op(input logic [2:0] o);
        return (o >= 3'd1) && (o <= 3'd4);
    endfunction

    // R4 R5: carry entering the sum
    function automatic logic ref_cin(input logic [2:0] o);
        logic [1:0] s;
        if (!arith_op(o)) return 1'b0;
        s = ci_cfg_pick ? ci_cfg_b : ci_cfg_a;
        case (s)
            2'd0:    return (o == 3'd1) || (o == 3'd4);
            2'd1:    return m_coq;
            2'd2:    return ci_routed;
            default: return ci_chained;
        endcase
    endfunction

    // returns {ov, co, y}
    function automatic logic [9:0] ref_alu(input logic [2:0] o, input logic [7:0] a,
                                           input logic [7:0] d, input logic ci);
        logic [7:0] b;
        logic [8:0] s;
        logic       v;
        case (o)
            3'd1:    b = 8'h00;
            3'd2:    b = 8'hFF;
            3'd3:    b = d;
            3'd4:    b = ~d;
            default: b = 8'h00;
        endcase
        s = {1'b0, a} + {1'b0, b} + {8'b0, ci};
        v = (a[7] == b[7]) && (s[7] != a[7]);
        return {v, s[8], s[7:0]};
    endfunction

    function automatic string op_tag(input logic [2:0] o);
        case (o)
            3'd1:    return "R1 R4 R5";
            3'd2:    return "R2 R4 R5";
            3'd3:    return "R3 R4 R5 R10";
            3'd4:    return "R3 R4 R5 R10";
            default: return "R9";
        endcase
    endfunction

    // called after inputs settle, before the rising edge
    task automatic check_and_advance();
        logic [9:0] r;
        logic       ci;
        ci = ref_cin(op);
        r  = ref_alu(op, m_acc[acc_sel], m_d[opnd_sel], ci);
        chk("R1 R2 R3 R9 acc0", {24'b0, acc_flat[7:0]},  {24'b0, m_acc[0]});
        chk("R1 R2 R3 R9 acc1", {24'b0, acc_flat[15:8]}, {24'b0, m_acc[1]});
        chk("R8 held carry",    {31'b0, co_held},        {31'b0, m_coq});
        chk(op_tag(op),         {24'b0, alu_y},          {24'b0, r[7:0]});
        chk("R6 carry out",     {31'b0, co_msb},         {31'b0, r[8]});
        chk("R7 overflow",      {31'b0, ov},             {31'b0, r[9]});
        if (arith_op(op)) begin
            m_acc[acc_sel] = r[7:0];
            m_coq          = r[8];
        end else if (op == 3'd5) begin
            m_acc[acc_sel] = load_data;
        end
        if (dreg_we) m_d[dreg_idx] = dreg_wdata;
    endtask

    task automatic step(input logic [2:0] o, input logic as, input logic bs,
                        input logic [1:0] ca, input logic [1:0] cb, input logic pk,
                        input logic rt, input logic ch, input logic we,
                        input logic wi, input logic [7:0] wd, input logic [7:0] ld);
        @(negedge clk);
        op = o; acc_sel = as; opnd_sel = bs; ci_cfg_a = ca; ci_cfg_b = cb;
        ci_cfg_pick = pk; ci_routed = rt; ci_chained = ch; dreg_we = we;
        dreg_idx = wi; dreg_wdata = wd; load_data = ld;
        #1;
        check_and_advance();
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_acc[0] = 8'h00; m_acc[1] = 8'h00; m_d[0] = 8'h00; m_d[1] = 8'h00; m_coq = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R10: reset state
        chk("R10 reset acc", {16'b0, acc_flat}, 32'h0);
        chk("R10 R8 reset held carry", {31'b0, co_held}, 32'h0);

        // R1 R6: wrap from all ones with carry out
        step(3'd5, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hFF);
        step(3'd1, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
        // R7: increment into most negative value
        step(3'd5, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h7F);
        step(3'd1, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
        // R2 R7: decrement of most negative value
        step(3'd5, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h80);
        step(3'd2, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
        // R8 R4: two-byte add over two cycles using the held carry
        step(3'd5, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h01, 8'hFF);
        step(3'd5, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00);
        step(3'd3, 1'b0, 1'b0, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
        step(3'd0, 1'b0, 1'b0, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
        step(3'd3, 1'b1, 1'b1, 2'd0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
        // R4 R5: chained carry 0 suppresses increment, routed 1 via setting B
        step(3'd1, 1'b0, 1'b0, 2'd3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
        step(3'd1, 1'b0, 1'b0, 2'd3, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
        // R3 R10: subtract while the operand is rewritten in the same cycle
        step(3'd4, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h55, 8'h00);
        step(3'd4, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
        // R9: reserved opcodes
        step(3'd6, 1'b0, 1'b0, 2'd1, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
        step(3'd7, 1'b1, 1'b0, 2'd1, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);

        for (int i = 0; i < 4000; i++) begin
            logic [2:0] o;
            int sel;
            sel = $urandom_range(0, 15);
            o = (sel < 11) ? 3'(1 + sel % 4) : 3'(sel - 8);
            step(o, 1'($urandom), 1'($urandom),
                 (sel[0] ? 2'd1 : 2'($urandom)), 2'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom), ($urandom_range(0, 3) == 0),
                 1'($urandom), 8'($urandom), 8'($urandom));
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule